// File: doc/BRIEF.md
# ADC Conversion Sequencer

This controller schedules conversions on an external successive-approximation converter core. The core is seen only through a handshake: the controller raises a one-cycle start pulse with a channel number, then waits for a done strobe carrying the result. Each result is written into a per-channel result register, and an interrupt pulse marks the completion of the programmed unit of work.

The controller is set up with one control word. The word holds a two-bit mode, a live channel field, a last-channel field, a timer-trigger select and a run enable. Two continuous modes are supported. In the first, one channel is converted again and again. In the second, the channels from 0 up to the last-channel value are converted in ascending order, and the scan then repeats. The live channel field works as the scan's progress counter. Conversions run while the enable bit is set. Software sets that bit directly, or a timer underflow strobe sets it when the timer trigger is selected.

Top module: `adc_seq_ctrl`

## Requirements
- R1: With mode code 2'b10, every start pulse carries the channel held in the live channel field, and the last-channel field has no effect.
- R2: With mode code 2'b10, one interrupt pulse follows every completed conversion.
- R3: With mode code 2'b11 and the live field loaded with 0, the channels 0, 1, ..., last are started in that order, and the sequence then repeats from 0.
- R4: With mode code 2'b11, exactly one interrupt pulse is raised per completed scan, in the cycle after the done of the last channel.
- R5: With mode code 2'b11, the live channel field tracks the channel being converted and reads 0 once a scan has finished.
- R6: With the timer select at 0, a bus write that sets the enable bit starts conversions, and a timer underflow strobe leaves the enable bit at 0.
- R7: With the timer select at 1, a timer underflow strobe sets the enable bit, and conversions then begin with no further bus write.
- R8: Writing 0 to the enable bit stops new start pulses. A conversion already in flight completes and its result is stored. A scan stopped before its last channel raises no interrupt, and its live field reads the channel after the one in flight.
- R9: Start pulses and interrupt pulses each last one cycle. While enabled, the next start follows in the cycle right after a done strobe.
- R10: Each result is stored in the register of the channel that was converted, and the register is read back combinationally through the result select port.
- R11: Mode codes 2'b00 and 2'b01 issue no start pulse, even with the enable bit set.
- R12: Control word layout: bits [1:0] mode, [2+CH_W-1:2] live channel, [2+2*CH_W-1:2+CH_W] last channel, bit 2+2*CH_W timer select, bit 3+2*CH_W enable. After reset the control word, all result registers, the start output and the interrupt output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_en | input | 1 | Write strobe for the control word |
| bus_wr_data | input | 2*CH_W+4 | Control word value to write |
| tmr_uflow | input | 1 | Timer underflow strobe |
| ctrl_rd | output | 2*CH_W+4 | Current control word |
| conv_start | output | 1 | One-cycle start pulse to the converter core |
| conv_ch | output | CH_W | Channel select to the converter core |
| conv_done | input | 1 | Conversion finished strobe from the core |
| conv_data | input | RES_W | Conversion result, valid with conv_done |
| res_sel | input | CH_W | Result register select |
| res_data | output | RES_W | Selected result register |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions assume that the core raises done only while a conversion is pending, and that in scan mode software loads the live field with a value no greater than the last channel. Some of them also assume that no bus write lands in the same cycle as a done strobe. The bench's core model answers a start with exactly one done after a fixed latency. Every stop write copies back the channel known to be in flight and happens in the middle of that conversion's latency, so no write collides with a done.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [1:0] {
      MODE_RSV0   = 2'b00,
      MODE_RSV1   = 2'b01,
      MODE_SINGLE = 2'b10,
      MODE_SCAN   = 2'b11
   } seq_mode_e;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'b00,
      SQ_ISSUE = 2'b01,
      SQ_WAIT  = 2'b10
   } seq_state_e;

endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs #(
   parameter int CH_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2*CH_W+3:0] wr_data,
   input  logic              tmr_uflow,
   input  logic              step,
   input  logic              wrap,
   output logic [2*CH_W+3:0] ctrl_q,
   output logic [1:0]        mode,
   output logic [CH_W-1:0]   cur_ch,
   output logic [CH_W-1:0]   fin_ch,
   output logic              tsel,
   output logic              run
);
   localparam int MODE_LO  = 0;
   localparam int CUR_LO   = 2;
   localparam int FIN_LO   = 2 + CH_W;
   localparam int TSEL_BIT = 2 + 2*CH_W;
   localparam int RUN_BIT  = 3 + 2*CH_W;

   assign mode   = ctrl_q[MODE_LO +: 2];
   assign cur_ch = ctrl_q[CUR_LO +: CH_W];
   assign fin_ch = ctrl_q[FIN_LO +: CH_W];
   assign tsel   = ctrl_q[TSEL_BIT];
   assign run    = ctrl_q[RUN_BIT];

   // bus write wins over every hardware update in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_en) begin
         ctrl_q <= wr_data;
      end else begin
         if (tsel && tmr_uflow)
            ctrl_q[RUN_BIT] <= 1'b1;
         if (wrap)
            ctrl_q[CUR_LO +: CH_W] <= '0;
         else if (step)
            ctrl_q[CUR_LO +: CH_W] <= cur_ch + 1'b1;
      end
   end

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
   import adc_seq_pkg::*;
#(
   parameter int CH_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic [1:0]      mode,
   input  logic [CH_W-1:0] cur_ch,
   input  logic [CH_W-1:0] fin_ch,
   input  logic            conv_done,
   output logic            conv_start,
   output logic            accept,
   output logic            step,
   output logic            wrap,
   output logic            waiting,
   output logic            irq
);
   seq_state_e state_q, state_d;
   logic       cont_mode, is_scan, is_single, last_ch, irq_d;

   assign cont_mode = mode[1];
   assign is_scan   = (mode == MODE_SCAN);
   assign is_single = (mode == MODE_SINGLE);
   assign last_ch   = (cur_ch == fin_ch);

   assign conv_start = (state_q == SQ_ISSUE);
   assign waiting    = (state_q == SQ_WAIT);
   assign accept     = waiting && conv_done;
   assign step       = accept && is_scan && !last_ch;
   assign wrap       = accept && is_scan && last_ch;
   assign irq_d      = accept && (is_single || (is_scan && last_ch));

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SQ_IDLE:  if (run && cont_mode) state_d = SQ_ISSUE;
         SQ_ISSUE: state_d = SQ_WAIT;
         SQ_WAIT:  if (conv_done) state_d = (run && cont_mode) ? SQ_ISSUE : SQ_IDLE;
         default:  state_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         irq     <= 1'b0;
      end else begin
         state_q <= state_d;
         irq     <= irq_d;
      end
   end

endmodule

// File: rtl/adc_seq_results.sv
module adc_seq_results #(
   parameter int CH_W   = 4,
   parameter int RES_W  = 10,
   parameter int NUM_CH = 16,
   parameter bit RD_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CH_W-1:0]  wa,
   input  logic [RES_W-1:0] wd,
   input  logic [CH_W-1:0]  ra,
   output logic [RES_W-1:0] rd
);
   logic [RES_W-1:0] ent_q [NUM_CH];
   logic [RES_W-1:0] rd_raw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_CH; i++) ent_q[i] <= '0;
      end else if (we) begin
         for (int i = 0; i < NUM_CH; i++)
            if (wa == CH_W'(i)) ent_q[i] <= wd;
      end
   end

   always_comb begin
      rd_raw = '0;
      for (int i = 0; i < NUM_CH; i++)
         if (ra == CH_W'(i)) rd_raw = ent_q[i];
   end

   generate
      if (RD_REG) begin : g_rd_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rd <= '0;
            else        rd <= rd_raw;
         end
      end else begin : g_rd_comb
         assign rd = rd_raw;
      end
   endgenerate

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
   parameter int CH_W   = 4,
   parameter int RES_W  = 10,
   parameter int NUM_CH = 16,
   parameter bit RD_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr_en,
   input  logic [2*CH_W+3:0] bus_wr_data,
   input  logic              tmr_uflow,
   output logic [2*CH_W+3:0] ctrl_rd,
   output logic              conv_start,
   output logic [CH_W-1:0]   conv_ch,
   input  logic              conv_done,
   input  logic [RES_W-1:0]  conv_data,
   input  logic [CH_W-1:0]   res_sel,
   output logic [RES_W-1:0]  res_data,
   output logic              irq
);
   localparam int MAX_CH = 1 << CH_W;

   generate
      if (CH_W < 1 || CH_W > 8) begin : g_bad_ch_w
         $error("adc_seq_ctrl: CH_W out of range");
      end
      if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_num_ch
         $error("adc_seq_ctrl: NUM_CH exceeds channel field range");
      end
      if (RES_W < 1) begin : g_bad_res_w
         $error("adc_seq_ctrl: RES_W must be positive");
      end
   endgenerate

   logic [1:0]      mode;
   logic [CH_W-1:0] cur_ch, fin_ch;
   logic            tsel, run;
   logic            step, wrap, accept, busy_wait;

   adc_seq_regs #(.CH_W(CH_W)) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (bus_wr_en),
      .wr_data   (bus_wr_data),
      .tmr_uflow (tmr_uflow),
      .step      (step),
      .wrap      (wrap),
      .ctrl_q    (ctrl_rd),
      .mode      (mode),
      .cur_ch    (cur_ch),
      .fin_ch    (fin_ch),
      .tsel      (tsel),
      .run       (run)
   );

   adc_seq_fsm #(.CH_W(CH_W)) fsm_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run),
      .mode       (mode),
      .cur_ch     (cur_ch),
      .fin_ch     (fin_ch),
      .conv_done  (conv_done),
      .conv_start (conv_start),
      .accept     (accept),
      .step       (step),
      .wrap       (wrap),
      .waiting    (busy_wait),
      .irq        (irq)
   );

   adc_seq_results #(
      .CH_W   (CH_W),
      .RES_W  (RES_W),
      .NUM_CH (NUM_CH),
      .RD_REG (RD_REG)
   ) res_i (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (accept),
      .wa    (cur_ch),
      .wd    (conv_data),
      .ra    (res_sel),
      .rd    (res_data)
   );

   assign conv_ch = cur_ch;

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
   parameter int CH_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr_en,
   input logic              tmr_uflow,
   input logic [2*CH_W+3:0] ctrl_rd,
   input logic              conv_start,
   input logic [CH_W-1:0]   conv_ch,
   input logic              conv_done,
   input logic              irq,
   input logic              busy_wait
);
   logic [1:0]      c_mode;
   logic [CH_W-1:0] c_cur, c_fin;
   logic            c_tsel, c_run;

   assign c_mode = ctrl_rd[1:0];
   assign c_cur  = ctrl_rd[2 +: CH_W];
   assign c_fin  = ctrl_rd[2+CH_W +: CH_W];
   assign c_tsel = ctrl_rd[2+2*CH_W];
   assign c_run  = ctrl_rd[3+2*CH_W];

   assert_irq_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   assert_start_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start);

   assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done && busy_wait && c_run && c_mode[1] && !bus_wr_en) |=> conv_start);

   assert_start_needs_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> $past(c_run));

   assert_no_start_rsv_mode_R11: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> $past(c_mode[1]));

   assert_scan_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_start && c_mode == 2'b11) |-> (conv_ch <= c_fin));

   assert_scan_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done && busy_wait && c_mode == 2'b11 && c_cur == c_fin && !bus_wr_en)
      |=> (c_cur == '0));

   assert_irq_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(conv_done && busy_wait));

   assert_run_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(c_run) |-> ($past(bus_wr_en) || ($past(tmr_uflow) && $past(c_tsel))));

   assert_timer_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!c_run && !c_tsel && !bus_wr_en) |=> !c_run);

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.CH_W(CH_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_wr_en  (bus_wr_en),
   .tmr_uflow  (tmr_uflow),
   .ctrl_rd    (ctrl_rd),
   .conv_start (conv_start),
   .conv_ch    (conv_ch),
   .conv_done  (conv_done),
   .irq        (irq),
   .busy_wait  (busy_wait)
);

// File: tb/adc_seq_ctrl_tb_top.sv
module adc_seq_ctrl_tb_top;
   localparam int CH_W   = 4;
   localparam int RES_W  = 10;
   localparam int NUM_CH = 16;
   localparam int LAT    = 3;
   localparam int CW     = 2*CH_W + 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_wr_en = 1'b0;
   logic [CW-1:0]     bus_wr_data = '0;
   logic              tmr_uflow = 1'b0;
   logic [CW-1:0]     ctrl_rd;
   logic              conv_start;
   logic [CH_W-1:0]   conv_ch;
   logic              conv_done = 1'b0;
   logic [RES_W-1:0]  conv_data = '0;
   logic [CH_W-1:0]   res_sel = '0;
   logic [RES_W-1:0]  res_data;
   logic              irq;

   always #2 clk = ~clk;

   adc_seq_ctrl #(.CH_W(CH_W), .RES_W(RES_W), .NUM_CH(NUM_CH)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_wr_data(bus_wr_data),
      .tmr_uflow(tmr_uflow), .ctrl_rd(ctrl_rd), .conv_start(conv_start),
      .conv_ch(conv_ch), .conv_done(conv_done), .conv_data(conv_data),
      .res_sel(res_sel), .res_data(res_data), .irq(irq)
   );

   int checks = 0;
   int errors = 0;
   int start_cnt = 0;
   int irq_cnt = 0;
   int nconv = 0;
   int log_ch [64];
   int exp_res [NUM_CH];
   bit prev_irq = 1'b0;
   bit in_scan = 1'b0;
   bit finished = 1'b0;

   task automatic chk_eq(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // R12 layout: {enable, timer select, last, live, mode}
   function automatic logic [CW-1:0] mk(input logic [1:0] m, input int cur,
                                        input int fin, input bit ts, input bit en);
      return {en, ts, CH_W'(fin), CH_W'(cur), m};
   endfunction

   // converter core model
   initial begin
      for (int i = 0; i < NUM_CH; i++) exp_res[i] = 0;
      forever begin
         @(negedge clk);
         conv_done = 1'b0;
         if (conv_start) begin
            int ch;
            ch = int'(conv_ch);
            repeat (LAT) @(negedge clk);
            nconv++;
            conv_data = RES_W'((ch * 37 + nconv * 11 + 5) % 1024);
            exp_res[ch] = int'(conv_data);
            conv_done = 1'b1;
         end
      end
   end

   // output monitor, sampled after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (rst_n) begin
            if (conv_start) begin
               if (start_cnt < 64) log_ch[start_cnt] = int'(conv_ch);
               start_cnt++;
            end
            if (irq) begin
               irq_cnt++;
               if (prev_irq) chk_eq("R9 irq longer than one cycle", 2, 1);
               if (in_scan) chk_eq("R5 live field at scan end", int'(ctrl_rd[2 +: CH_W]), 0);
            end
            prev_irq = irq;
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic bus_write(input logic [CW-1:0] d);
      bus_wr_en = 1'b1;
      bus_wr_data = d;
      @(negedge clk);
      bus_wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_starts(input int n);
      while (start_cnt < n) @(negedge clk);
   endtask

   task automatic clear_counts();
      start_cnt = 0;
      irq_cnt = 0;
   endtask

   task automatic rd_result(input int ch, output int val);
      res_sel = CH_W'(ch);
      #1;
      val = int'(res_data);
   endtask

   initial begin
      int v;
      repeat (5) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R12 reset state
      chk_eq("R12 reset control word", int'(ctrl_rd), 0);
      chk_eq("R12 reset start", int'(conv_start), 0);
      chk_eq("R12 reset irq", int'(irq), 0);
      for (int c = 0; c < NUM_CH; c++) begin
         rd_result(c, v);
         chk_eq("R12 reset result", v, 0);
      end
      @(negedge clk);

      // R11 reserved modes with enable set
      for (int m = 0; m < 2; m++) begin
         clear_counts();
         bus_write(mk(2'(m), 1, 3, 1'b0, 1'b1));
         idle(20);
         chk_eq("R11 no start in reserved mode", start_cnt, 0);
         bus_write(mk(2'(m), 1, 3, 1'b0, 1'b0));
         idle(2);
      end

      // R1 R2 R6 R8 R10 single-channel sweep
      for (int n = 0; n < NUM_CH; n++) begin
         clear_counts();
         bus_write(mk(2'b10, n, NUM_CH - 1 - n, 1'b0, 1'b1));
         wait_starts(3);
         bus_write(mk(2'b10, n, NUM_CH - 1 - n, 1'b0, 1'b0));
         idle(20);
         chk_eq("R8 single starts after stop", start_cnt, 3);
         for (int i = 0; i < 3; i++) chk_eq("R1 single channel", log_ch[i], n);
         chk_eq("R2 one irq per conversion", irq_cnt, 3);
         chk_eq("R8 enable reads 0", int'(ctrl_rd), int'(mk(2'b10, n, NUM_CH - 1 - n, 1'b0, 1'b0)));
         rd_result(n, v);
         chk_eq("R10 single result", v, exp_res[n]);
         @(negedge clk);
      end

      // R3 R4 R5 R10 scan sweep, two full passes each
      for (int f = 0; f < NUM_CH; f++) begin
         clear_counts();
         in_scan = 1'b1;
         bus_write(mk(2'b11, 0, f, 1'b0, 1'b1));
         wait_starts(2 * (f + 1));
         bus_write(mk(2'b11, f, f, 1'b0, 1'b0));
         idle(20);
         in_scan = 1'b0;
         chk_eq("R3 scan start count", start_cnt, 2 * (f + 1));
         for (int i = 0; i < 2 * (f + 1); i++)
            if (i < 64) chk_eq("R3 scan order", log_ch[i], i % (f + 1));
         chk_eq("R4 one irq per scan", irq_cnt, 2);
         chk_eq("R5 live field back to 0", int'(ctrl_rd[2 +: CH_W]), 0);
         for (int c = 0; c <= f; c++) begin
            rd_result(c, v);
            chk_eq("R10 scan result", v, exp_res[c]);
         end
         @(negedge clk);
      end

      // R8 partial scan stop
      clear_counts();
      bus_write(mk(2'b11, 0, 5, 1'b0, 1'b1));
      wait_starts(3);
      bus_write(mk(2'b11, 2, 5, 1'b0, 1'b0));
      idle(20);
      chk_eq("R8 partial scan starts", start_cnt, 3);
      chk_eq("R8 partial scan no irq", irq_cnt, 0);
      chk_eq("R8 partial scan live field", int'(ctrl_rd[2 +: CH_W]), 3);
      rd_result(2, v);
      chk_eq("R8 in-flight result stored", v, exp_res[2]);
      @(negedge clk);

      // R6 timer strobe ignored without timer select
      clear_counts();
      bus_write(mk(2'b10, 2, 0, 1'b0, 1'b0));
      tmr_uflow = 1'b1;
      @(negedge clk);
      tmr_uflow = 1'b0;
      idle(15);
      chk_eq("R6 timer ignored, no start", start_cnt, 0);
      chk_eq("R6 timer ignored, enable 0", int'(ctrl_rd[CW-1]), 0);

      // R7 timer strobe sets enable
      bus_write(mk(2'b10, 2, 0, 1'b1, 1'b0));
      idle(10);
      chk_eq("R7 no start before underflow", start_cnt, 0);
      tmr_uflow = 1'b1;
      @(negedge clk);
      tmr_uflow = 1'b0;
      chk_eq("R7 enable set by underflow", int'(ctrl_rd[CW-1]), 1);
      wait_starts(2);
      bus_write(mk(2'b10, 2, 0, 1'b1, 1'b0));
      idle(20);
      chk_eq("R7 timer-started conversions", start_cnt, 2);
      chk_eq("R7 timer-started irq count", irq_cnt, 2);
      chk_eq("R7 channel", log_ch[1], 2);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule